// File: doc/BRIEF.md
# External Interrupt Line Controller

This block turns pin transitions into interrupt requests. It watches sixteen interrupt lines. Line n follows pin n of one GPIO port, and software picks that port. Every selected pin first passes through a two-flop synchronizer. The block then compares the synchronized value with its value one cycle earlier to find rising and falling transitions. An enabled transition on a line sets that line's pending flag. A pending flag reaches an interrupt output only when the line's mask bit is open.

Software reaches all configuration through a 16-bit register bus with a write strobe, a word address and a combinational read port. Pending flags are cleared by writing ones: software can read the pending word and write that same value back. The sixteen lines share seven interrupt request outputs. The five lowest lines each have their own output, and the other eleven lines are combined into two shared outputs.

Top module: `extint_ctrl`

## Requirements
- R1: Line n samples pin n of the port whose index is held in the 4-bit field at bits [4*(n%4)+3 : 4*(n%4)] of the source word at address n/4 (addresses 0 to 3). The index selects gpioPins[index*16 + n], and index 0 means the first port. The source words read back as written.
- R2: A source index from 6 to 15 ties the line to a constant 0, so activity on any pin cannot set that line's pending flag.
- R3: Bit n of the rising-enable word (address 4) allows a 0-to-1 transition on line n to set pending bit n. The flag can be read on the third clock edge after the pin changes. A falling transition on a line with only rising enabled sets nothing.
- R4: Bit n of the falling-enable word (address 5) allows a 1-to-0 transition to set pending bit n. If both enables are set, either direction sets the flag.
- R5: The pending word (address 7) is cleared bit by bit: writing 1 clears that bit, and writing 0 leaves the bit unchanged.
- R6: If a transition and a clear write for the same line land on the same clock edge, the pending bit ends up set.
- R7: Mask bit n (address 6) gates pending bit n onto the outputs. A pending bit is set whatever the mask state.
- R8: irqOut[k] for k = 0 to 4 carries masked line k. irqOut[5] is the OR of masked lines 5 to 9, and irqOut[6] is the OR of masked lines 10 to 15.
- R9: Reset clears every register and the synchronizers, so all pending flags and all outputs read zero.
- R10: Registers are 16 bits wide and read back as written. Addresses 8 to 15 read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| regWrite | input | 1 | Write strobe for the register bus |
| regAddr | input | 4 | Word address |
| regWdata | input | 16 | Write data |
| regRdata | output | 16 | Read data for regAddr, combinational |
| gpioPins | input | 96 | Pins of six ports, port p pin n at bit p*16+n |
| irqOut | output | 7 | Grouped interrupt requests |

## Verification
The bench raises and lowers pins on lines that have only the rising enable, only the falling enable, or both. The rising-only and falling-only cases catch a swapped or merged edge decode. The same lines are then run with the mask closed and open, which separates setting a flag from driving an output. Pins on a dedicated line and on each shared group are raised one after another, so the outputs show whether a line is routed to the wrong output. A line is moved to another port and to an index past the last port, and pins are driven on both the old and the new source, which shows whether the selector is used. One transition is placed on the same edge as a clear write to check that the set takes priority.

// File: rtl/extint_pkg.sv
package extint_pkg;
  localparam int LINES      = 16;
  localparam int PORTS      = 6;
  localparam int SEL_W      = 4;
  localparam int FIELDS     = 4;
  localparam int SEL_REGS   = LINES / FIELDS;
  localparam int REG_W      = 16;
  localparam int ADDR_W     = 4;
  localparam int SOLO_LINES = 5;
  localparam int GRP_A_LAST = 9;
  localparam int IRQ_OUTS   = SOLO_LINES + 2;

  localparam logic [ADDR_W-1:0] ADDR_RISE = 4'd4;
  localparam logic [ADDR_W-1:0] ADDR_FALL = 4'd5;
  localparam logic [ADDR_W-1:0] ADDR_MASK = 4'd6;
  localparam logic [ADDR_W-1:0] ADDR_PEND = 4'd7;

  typedef struct packed {
    logic [SEL_REGS-1:0] selWe;
    logic                riseWe;
    logic                fallWe;
    logic                maskWe;
    logic                pendClr;
    logic [REG_W-1:0]    wrData;
  } strobe_t;
endpackage

// File: rtl/extint_regs.sv
module extint_regs
  import extint_pkg::*;
(
  input  logic                   regWrite,
  input  logic [ADDR_W-1:0]      regAddr,
  input  logic [REG_W-1:0]       regWdata,
  input  logic [LINES*SEL_W-1:0] selVec,
  input  logic [LINES-1:0]       riseVec,
  input  logic [LINES-1:0]       fallVec,
  input  logic [LINES-1:0]       maskVec,
  input  logic [LINES-1:0]       pendVec,
  output strobe_t                strb,
  output logic [REG_W-1:0]       regRdata
);
  localparam int SEL_REG_W = SEL_W * FIELDS;

  always_comb begin
    strb        = '0;
    strb.wrData = regWdata;
    if (regWrite) begin
      for (int i = 0; i < SEL_REGS; i++) begin
        if (regAddr == ADDR_W'(i)) strb.selWe[i] = 1'b1;
      end
      strb.riseWe  = (regAddr == ADDR_RISE);
      strb.fallWe  = (regAddr == ADDR_FALL);
      strb.maskWe  = (regAddr == ADDR_MASK);
      strb.pendClr = (regAddr == ADDR_PEND);
    end
  end

  always_comb begin
    regRdata = '0;
    for (int i = 0; i < SEL_REGS; i++) begin
      if (regAddr == ADDR_W'(i)) regRdata = REG_W'(selVec[i*SEL_REG_W +: SEL_REG_W]);
    end
    case (regAddr)
      ADDR_RISE: regRdata = riseVec;
      ADDR_FALL: regRdata = fallVec;
      ADDR_MASK: regRdata = maskVec;
      ADDR_PEND: regRdata = pendVec;
      default: ;
    endcase
  end
endmodule

// File: rtl/extint_datapath.sv
module extint_datapath
  import extint_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  strobe_t                strb,
  input  logic [PORTS*LINES-1:0] gpioPins,
  output logic [LINES*SEL_W-1:0] selVec,
  output logic [LINES-1:0]       riseVec,
  output logic [LINES-1:0]       fallVec,
  output logic [LINES-1:0]       maskVec,
  output logic [LINES-1:0]       pendVec,
  output logic [IRQ_OUTS-1:0]    irqOut
);
  localparam int SEL_REG_W = SEL_W * FIELDS;
  localparam int PAD_W     = 1 << SEL_W;

  logic [LINES-1:0] lineSrc, syncA, syncB, prevQ;
  logic [LINES-1:0] riseHit, fallHit, clrBits, gated;

  // per-line source multiplexer; indices past the last port read zero
  for (genvar n = 0; n < LINES; n++) begin : g_src
    logic [PAD_W-1:0] padded;
    logic [SEL_W-1:0] srcIdx;
    always_comb begin
      srcIdx = selVec[n*SEL_W +: SEL_W];
      padded = '0;
      for (int p = 0; p < PORTS; p++) padded[p] = gpioPins[p*LINES + n];
      lineSrc[n] = padded[srcIdx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      syncA <= '0;
      syncB <= '0;
      prevQ <= '0;
    end else begin
      syncA <= lineSrc;
      syncB <= syncA;
      prevQ <= syncB;
    end
  end

  assign riseHit = syncB & ~prevQ & riseVec;
  assign fallHit = ~syncB & prevQ & fallVec;
  assign clrBits = strb.pendClr ? strb.wrData[LINES-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      selVec  <= '0;
      riseVec <= '0;
      fallVec <= '0;
      maskVec <= '0;
      pendVec <= '0;
    end else begin
      for (int i = 0; i < SEL_REGS; i++) begin
        if (strb.selWe[i]) selVec[i*SEL_REG_W +: SEL_REG_W] <= strb.wrData[SEL_REG_W-1:0];
      end
      if (strb.riseWe) riseVec <= strb.wrData[LINES-1:0];
      if (strb.fallWe) fallVec <= strb.wrData[LINES-1:0];
      if (strb.maskWe) maskVec <= strb.wrData[LINES-1:0];
      // a new edge outranks a clear landing on the same edge
      pendVec <= (pendVec & ~clrBits) | riseHit | fallHit;
    end
  end

  assign gated = pendVec & maskVec;

  for (genvar k = 0; k < SOLO_LINES; k++) begin : g_solo
    assign irqOut[k] = gated[k];
  end
  assign irqOut[SOLO_LINES]   = |gated[GRP_A_LAST:SOLO_LINES];
  assign irqOut[SOLO_LINES+1] = |gated[LINES-1:GRP_A_LAST+1];
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
  import extint_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   regWrite,
  input  logic [ADDR_W-1:0]      regAddr,
  input  logic [REG_W-1:0]       regWdata,
  output logic [REG_W-1:0]       regRdata,
  input  logic [PORTS*LINES-1:0] gpioPins,
  output logic [IRQ_OUTS-1:0]    irqOut
);
  strobe_t                strb;
  logic [LINES*SEL_W-1:0] selVec;
  logic [LINES-1:0]       riseVec, fallVec, maskVec, pendVec;

  extint_regs u_regs (
    .regWrite(regWrite), .regAddr(regAddr), .regWdata(regWdata),
    .selVec(selVec), .riseVec(riseVec), .fallVec(fallVec),
    .maskVec(maskVec), .pendVec(pendVec),
    .strb(strb), .regRdata(regRdata)
  );

  extint_datapath u_dp (
    .clk(clk), .rst(rst), .strb(strb), .gpioPins(gpioPins),
    .selVec(selVec), .riseVec(riseVec), .fallVec(fallVec),
    .maskVec(maskVec), .pendVec(pendVec), .irqOut(irqOut)
  );
endmodule

// File: rtl/extint_checker.sv
module extint_checker
  import extint_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                regWrite,
  input logic [ADDR_W-1:0]   regAddr,
  input logic [REG_W-1:0]    regWdata,
  input logic [LINES-1:0]    riseVec,
  input logic [LINES-1:0]    fallVec,
  input logic [LINES-1:0]    maskVec,
  input logic [LINES-1:0]    pendVec,
  input logic [IRQ_OUTS-1:0] irqOut
);
  logic [LINES-1:0] busClr;
  assign busClr = (regWrite && regAddr == ADDR_PEND) ? regWdata[LINES-1:0] : '0;

  // R5: a pending bit only drops when a bus write cleared it
  a_r5_clear_only_by_write: assert property (@(posedge clk) disable iff (rst)
    (($past(pendVec) & ~$past(busClr) & ~pendVec) == '0));

  // R7: with every mask bit closed no output is raised
  a_r7_mask_gates: assert property (@(posedge clk) disable iff (rst)
    (maskVec == '0) |-> (irqOut == '0));

  // R8: shared outputs need a pending line in their group
  a_r8_group_a: assert property (@(posedge clk) disable iff (rst)
    irqOut[SOLO_LINES] |-> (|pendVec[GRP_A_LAST:SOLO_LINES]));
  a_r8_group_b: assert property (@(posedge clk) disable iff (rst)
    irqOut[SOLO_LINES+1] |-> (|pendVec[LINES-1:GRP_A_LAST+1]));

  // R3 and R4: a flag only rises on a line with some edge enabled
  for (genvar i = 0; i < LINES; i++) begin : g_en
    a_r3_edge_needs_enable: assert property (@(posedge clk) disable iff (rst)
      $rose(pendVec[i]) |-> ($past(riseVec[i]) || $past(fallVec[i])));
  end

  // R9: leaving reset finds everything clear
  a_r9_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pendVec == '0 && irqOut == '0 && maskVec == '0));
endmodule

bind extint_ctrl extint_checker u_chk (
  .clk(clk), .rst(rst), .regWrite(regWrite), .regAddr(regAddr),
  .regWdata(regWdata), .riseVec(riseVec), .fallVec(fallVec),
  .maskVec(maskVec), .pendVec(pendVec), .irqOut(irqOut)
);

// File: tb/extint_ctrl_test.sv
module extint_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        regWrite = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic [95:0] gpioPins = '0;
  logic [6:0]  irqOut;

  int checks = 0;
  int fails  = 0;
  logic probe = 1'b0;
  logic done = 1'b0;

  typedef struct {
    string      req;
    bit         isIrq;
    logic [15:0] exp;
  } item_t;
  item_t sbq[$];

  always #5 clk = ~clk;

  extint_ctrl uut (
    .clk(clk), .rst(rst), .regWrite(regWrite), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .gpioPins(gpioPins),
    .irqOut(irqOut)
  );

  // monitor: pops the expected item and compares away from the active edge
  always @(negedge clk) begin : mon
    item_t it;
    logic [15:0] act;
    if (probe && sbq.size() > 0) begin
      it = sbq.pop_front();
      act = it.isIrq ? {9'b0, irqOut} : regRdata;
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic writeReg(input logic [3:0] a, input logic [15:0] d);
    tick();
    regWrite = 1'b1; regAddr = a; regWdata = d;
    tick();
    regWrite = 1'b0;
  endtask

  task automatic setPin(input int port, input int pin, input logic v);
    tick();
    gpioPins[port*16 + pin] = v;
  endtask

  task automatic idle(input int n);
    repeat (n) tick();
  endtask

  task automatic checkReg(input logic [3:0] a, input logic [15:0] e, input string req);
    item_t it;
    tick();
    regAddr = a;
    it.req = req; it.isIrq = 1'b0; it.exp = e;
    sbq.push_back(it);
    probe = 1'b1;
    @(negedge clk); #1;
    probe = 1'b0;
  endtask

  task automatic checkIrq(input logic [6:0] e, input string req);
    item_t it;
    tick();
    it.req = req; it.isIrq = 1'b1; it.exp = {9'b0, e};
    sbq.push_back(it);
    probe = 1'b1;
    @(negedge clk); #1;
    probe = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog (R1 to R10 run): actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R9 reset state
    checkReg(4'd7, 16'h0000, "R9 pending after reset");
    checkReg(4'd6, 16'h0000, "R9 mask after reset");
    checkIrq(7'h00, "R9 outputs after reset");

    // R10 width and unmapped space
    writeReg(4'd4, 16'hFFFF);
    checkReg(4'd4, 16'hFFFF, "R10 rising word readback");
    writeReg(4'd9, 16'h1234);
    checkReg(4'd9, 16'h0000, "R10 unmapped address reads zero");
    writeReg(4'd4, 16'h0000);

    // R3 rising only on line 1
    writeReg(4'd4, 16'h0002);
    setPin(0, 1, 1'b1); idle(4);
    checkReg(4'd7, 16'h0002, "R3 rising edge sets pending");
    writeReg(4'd7, 16'h0002);
    checkReg(4'd7, 16'h0000, "R5 write one clears");
    setPin(0, 1, 1'b0); idle(4);
    checkReg(4'd7, 16'h0000, "R3 falling edge ignored when only rising enabled");

    // R4 falling only on line 2
    writeReg(4'd5, 16'h0004);
    setPin(0, 2, 1'b1); idle(4);
    checkReg(4'd7, 16'h0000, "R4 rising edge ignored when only falling enabled");
    setPin(0, 2, 1'b0); idle(4);
    checkReg(4'd7, 16'h0004, "R4 falling edge sets pending");
    writeReg(4'd7, 16'h0000);
    checkReg(4'd7, 16'h0004, "R5 write zero has no effect");
    writeReg(4'd7, 16'h0004);

    // R4 both edges on line 4
    writeReg(4'd4, 16'h0012);
    writeReg(4'd5, 16'h0014);
    setPin(0, 4, 1'b1); idle(4);
    checkReg(4'd7, 16'h0010, "R4 both enabled rising");
    writeReg(4'd7, 16'h0010);
    setPin(0, 4, 1'b0); idle(4);
    checkReg(4'd7, 16'h0010, "R4 both enabled falling");
    writeReg(4'd7, 16'h0010);

    // R7 masking
    setPin(0, 4, 1'b1); idle(4);
    checkReg(4'd7, 16'h0010, "R7 pending set while masked");
    checkIrq(7'h00, "R7 masked line keeps output low");
    writeReg(4'd6, 16'h0010);
    checkIrq(7'h10, "R7 unmasked line drives its output");
    writeReg(4'd7, 16'h0010);
    checkIrq(7'h00, "R7 output drops after clear");

    // R8 grouping
    writeReg(4'd4, 16'h109A);
    writeReg(4'd6, 16'hFFFF);
    setPin(0, 7, 1'b1); idle(4);
    checkIrq(7'h20, "R8 line 7 on first shared output");
    setPin(0, 12, 1'b1); idle(4);
    checkIrq(7'h60, "R8 line 12 on second shared output");
    setPin(0, 3, 1'b1); idle(4);
    checkIrq(7'h68, "R8 line 3 on its own output");
    checkReg(4'd7, 16'h1088, "R8 pending word");
    writeReg(4'd7, 16'hFFFF);
    checkIrq(7'h00, "R8 all outputs low after clear");

    // R1 source select: line 5 from port index 2
    writeReg(4'd1, 16'h0020);
    writeReg(4'd4, 16'h10BA);
    checkReg(4'd1, 16'h0020, "R1 source word readback");
    setPin(0, 5, 1'b1); idle(4);
    checkReg(4'd7, 16'h0000, "R1 unselected port ignored");
    setPin(2, 5, 1'b1); idle(4);
    checkReg(4'd7, 16'h0020, "R1 selected port sets pending");
    checkIrq(7'h20, "R1 line 5 on shared output");
    writeReg(4'd7, 16'h0020);

    // R2 index past last port
    writeReg(4'd0, 16'h0007);
    writeReg(4'd4, 16'h10BB);
    for (int p = 0; p < 6; p++) setPin(p, 0, 1'b1);
    idle(4);
    checkReg(4'd7, 16'h0000, "R2 out-of-range port gives constant zero");
    checkReg(4'd0, 16'h0007, "R1 source word 0 readback");

    // R6 edge and clear on the same edge
    setPin(0, 1, 1'b1);
    tick();
    writeReg(4'd7, 16'h0002);
    checkReg(4'd7, 16'h0002, "R6 edge wins over simultaneous clear");
    checkIrq(7'h02, "R6 output raised");
    writeReg(4'd7, 16'h0002);
    checkReg(4'd7, 16'h0000, "R5 clear after collision");

    idle(2);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule